// File: doc/BRIEF.md
# Two-Button Sequence Combination Lock

A clocked lock controller driven by two push buttons, called A and B. Beginning in its idle start position, it releases the lock only when the user enters one of two accepted press orders: A B A B, or A A B A B. The two orders share a leading A, so the machine tracks both candidates at once until they diverge.

Any press that continues neither accepted order sends the machine to a failure position. It stays there until the user presses both buttons in the same cycle, which returns it to start from any position, including the open one. Once open, the lock stays open and ignores single-button presses until the same two-button clear.

The button inputs are taken to be clean, single-cycle press pulses; debouncing and edge detection belong to a stage in front of this block. A synchronous reset forces the start position.

Top module: `seq_lock`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, the machine enters start; in the cycle after, `locked` reads 1.
- R2: From start, the single presses A, B, A, B (in that order) open the lock. `locked` becomes 0 in the cycle after the clock edge that samples the final B.
- R3: From start, the single presses A, A, B, A, B (in that order) open the lock, with the same output timing as R2.
- R4: A single press that continues neither accepted order moves the machine to fail. The machine stays in fail through any later single presses, so a correct order entered afterwards leaves `locked` at 1.
- R5: A cycle with `press_a` and `press_b` both 1 returns the machine to start from every position, including fail and open. An accepted order entered afterwards opens the lock.
- R6: A cycle with neither button pressed leaves the position unchanged, so idle cycles between presses do not affect the result.
- R7: In the open position, a press of A alone or B alone is ignored, and `locked` stays 0.
- R8: `locked` is 0 only in the open position and 1 in every other position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; forces start |
| press_a | input | 1 | One-cycle press pulse of button A |
| press_b | input | 1 | One-cycle press pulse of button B |
| locked | output | 1 | 1 = lock closed, 0 = lock open |

## Verification
On every cycle, the assertions check these properties: a two-button press leads to start; an idle cycle holds the position; fail and open persist under single presses; `locked` drops only after a B press from one of the two positions just before open. Only the bench's scenarios can show that the full press orders open the lock, and that no other order does. To show this, the bench enters every A/B order of length one to six, each from start and with idle cycles mixed in. It compares `locked` against a prefix rule worked out by arithmetic, then checks that the lock recovers from fail and from open.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;

  typedef enum logic [3:0] {
    ST_START = 4'd0,
    ST_A     = 4'd1,
    ST_AA    = 4'd2,
    ST_AB    = 4'd3,
    ST_AAB   = 4'd4,
    ST_ABA   = 4'd5,
    ST_AABA  = 4'd6,
    ST_OPEN  = 4'd7,
    ST_FAIL  = 4'd8
  } lock_state_t;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_A    = 2'd1,
    EV_B    = 2'd2,
    EV_BOTH = 2'd3
  } press_ev_t;

  // Transition for a single press of A or B; both/none are handled by caller.
  function automatic lock_state_t step_single(lock_state_t cur, logic is_b);
    lock_state_t nxt;
    case (cur)
      ST_START: nxt = is_b ? ST_FAIL : ST_A;
      ST_A:     nxt = is_b ? ST_AB   : ST_AA;
      ST_AA:    nxt = is_b ? ST_AAB  : ST_FAIL;
      ST_AB:    nxt = is_b ? ST_FAIL : ST_ABA;
      ST_AAB:   nxt = is_b ? ST_FAIL : ST_AABA;
      ST_ABA:   nxt = is_b ? ST_OPEN : ST_FAIL;
      ST_AABA:  nxt = is_b ? ST_OPEN : ST_FAIL;
      ST_OPEN:  nxt = ST_OPEN;
      default:  nxt = ST_FAIL;
    endcase
    return nxt;
  endfunction

  function automatic lock_state_t step(lock_state_t cur, press_ev_t ev);
    lock_state_t nxt;
    case (ev)
      EV_BOTH: nxt = ST_START;
      EV_A:    nxt = step_single(cur, 1'b0);
      EV_B:    nxt = step_single(cur, 1'b1);
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/seq_lock_press_dec.sv
module seq_lock_press_dec
  import seq_lock_pkg::*;
(
  input  logic      press_a,
  input  logic      press_b,
  output press_ev_t ev
);
  always_comb begin
    ev = EV_NONE;
    if (press_a && press_b)  ev = EV_BOTH;
    else if (press_a)        ev = EV_A;
    else if (press_b)        ev = EV_B;
  end
endmodule

// File: rtl/seq_lock_fsm.sv
module seq_lock_fsm
  import seq_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  press_ev_t   ev,
  output lock_state_t state
);
  lock_state_t state_q;
  lock_state_t state_d;

  always_comb state_d = step(state_q, ev);

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_START;
    else     state_q <= state_d;
  end

  assign state = state_q;

  // R1: reset leads to start
  p_reset_start_r1: assert property (@(posedge clk) rst |=> state_q == ST_START);
  // R5: two-button press clears to start
  p_both_start_r5: assert property (@(posedge clk) disable iff (rst)
    ev == EV_BOTH |=> state_q == ST_START);
  // R6: idle cycle holds position
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ev == EV_NONE |=> $stable(state_q));
  // R4: fail is sticky under single presses
  p_fail_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FAIL && ev != EV_BOTH) |=> state_q == ST_FAIL);
  // R7: open is kept under single presses
  p_open_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OPEN && ev != EV_BOTH) |=> state_q == ST_OPEN);
endmodule

// File: rtl/seq_lock_out.sv
module seq_lock_out
  import seq_lock_pkg::*;
(
  input  lock_state_t state,
  output logic        locked
);
  always_comb locked = (state != ST_OPEN);
endmodule

// File: rtl/seq_lock.sv
module seq_lock
  import seq_lock_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic press_a,
  input  logic press_b,
  output logic locked
);
  press_ev_t   ev_w;
  lock_state_t state_w;

  seq_lock_press_dec u_dec (.press_a(press_a), .press_b(press_b), .ev(ev_w));
  seq_lock_fsm       u_fsm (.clk(clk), .rst(rst), .ev(ev_w), .state(state_w));
  seq_lock_out       u_out (.state(state_w), .locked(locked));

  // R2/R3: the lock opens only on a B press from the last step of an accepted order
  p_open_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (locked && ev_w == EV_B && (state_w == ST_ABA || state_w == ST_AABA)) |=> !locked);
  p_open_cause_r3: assert property (@(posedge clk) disable iff (rst)
    (locked && !(ev_w == EV_B && (state_w == ST_ABA || state_w == ST_AABA))) |=> locked);
  // R8: unlocked implies the open position
  p_unlocked_open_r8: assert property (@(posedge clk) disable iff (rst)
    !locked |-> state_w == ST_OPEN);
endmodule

// File: tb/seq_lock_tb.sv
module seq_lock_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic press_a = 1'b0;
  logic press_b = 1'b0;
  logic locked;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  seq_lock dut_i (.clk(clk), .rst(rst), .press_a(press_a), .press_b(press_b), .locked(locked));

  task automatic check(input logic exp, input string req);
    n_run++;
    if (locked !== exp) begin
      n_fail++;
      $display("FAIL %s: locked=%b expected=%b", req, locked, exp);
    end
  endtask

  // drive one cycle of buttons at negedge, release at next negedge
  task automatic press(input logic a, input logic b);
    @(negedge clk); press_a = a; press_b = b;
    @(negedge clk); press_a = 1'b0; press_b = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // bit i of pat: 1 = B, 0 = A. Open iff the first n presses begin with ABAB or AABAB.
  function automatic logic exp_locked(input int pat, input int n);
    logic abab, aabab;
    abab  = (n >= 4) && ((pat & 4'hF)  == 4'b1010);
    aabab = (n >= 5) && ((pat & 5'h1F) == 5'b10100);
    return !(abab || aabab);
  endfunction

  task automatic seq(input int pat, input int n);
    for (int i = 0; i < n; i++) press(1'b0 == ((pat >> i) & 1) ? 1'b0 : 1'b0, 1'b0) ;
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    check(1'b1, "R1 reset locked");
    // exhaustive sweep of orders length 1..6, idle cycles interleaved (R6)
    for (int len = 1; len <= 6; len++) begin
      for (int pat = 0; pat < (1 << len); pat++) begin
        press(1'b1, 1'b1);
        check(1'b1, "R5 clear to start");
        for (int i = 0; i < len; i++) begin
          logic isb;
          isb = ((pat >> i) & 1) != 0;
          press(!isb, isb);
          if ((pat + i) % 3 == 0) idle(2);
          check(exp_locked(pat, i + 1), "R2/R3/R4/R6 sweep step");
        end
      end
    end
    // R2 explicit
    press(1'b1, 1'b1);
    press(1,0); press(0,1); press(1,0); check(1'b1, "R8 locked before last press");
    press(0,1); check(1'b0, "R2 ABAB opens");
    // R7 single presses ignored in open
    press(1,0); check(1'b0, "R7 A ignored in open");
    press(0,1); check(1'b0, "R7 B ignored in open");
    idle(4); check(1'b0, "R6 idle holds open");
    // R5 from open
    press(1,1); check(1'b1, "R5 open to start");
    // R3 explicit
    press(1,0); press(1,0); press(0,1); press(1,0); press(0,1);
    check(1'b0, "R3 AABAB opens");
    // R4 sticky fail then correct order
    press(1,1); press(0,1); check(1'b1, "R4 fail entered");
    press(1,0); press(0,1); press(1,0); press(0,1);
    check(1'b1, "R4 fail sticky after ABAB");
    // R5 from fail
    press(1,1); press(1,0); press(0,1); press(1,0); press(0,1);
    check(1'b0, "R5 recover from fail");
    // R1 reset from open
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(1'b1, "R1 reset from open");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule